// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a simple synchronous request port into the strobe sequences an asynchronous fast-page-mode DRAM needs. A request carries a 19-bit word address, a read/write flag and write data under a valid/ready handshake. The controller drives row strobe, column strobe, write enable, output enable, a 10-bit multiplexed address bus and a split data bus (output, output enable, input). Read data comes back with a one-cycle valid pulse, in request order.

Once a row has been opened, RAS is held low and later requests that fall in the same row issue only a new column address and a CAS pulse. A request to another row closes the current one, waits out precharge and opens the new row. The open row is closed after a run of idle cycles, or when the RAS-low time nears its ceiling. Every DRAM minimum time is a parameter counted in controller clock cycles. Writes always lower WE before CAS falls, so the device never drives its pins during a write.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The upper 10 address bits (18:9) are on the address pins when RAS falls and stay unchanged across that edge; the lower 9 bits (8:0) are on the pins when CAS falls.
- R2: Each RAS-low period lasts at least T_RAS cycles.
- R3: RAS stays high for at least T_RP cycles before it falls again, and CAS stays high for at least T_CP cycles between two column pulses.
- R4: A read holds WE high, drives OE low only while CAS is low, releases the data bus, and returns the last data written to that address (the memory's initial content if never written).
- R5: A write lowers WE at least one cycle before CAS falls and holds it low until CAS rises; OE stays high, and the data bus enable is on from before the CAS fall until after CAS rises, carrying the request's write data.
- R6: Back-to-back requests to the same row cause exactly one RAS fall.
- R7: A request to a row other than the open one raises RAS, precharges, and opens the new row with one further RAS fall, with correct data.
- R8: Read data is captured only after at least T_CAC cycles of CAS low and at least T_CAA cycles of a stable column address.
- R9: With no requests, an open row is closed (RAS high) within IDLE_MAX + T_RAS + T_CP + 4 cycles of the last column pulse.
- R10: No RAS-low period exceeds RAS_MAX cycles, even under a continuous stream of same-row requests.
- R11: Ready is low while CAS is low and in the cycle RAS rises; each read gives one rsp_valid pulse of one cycle, in request order.
- R12: Out of reset RAS, CAS, WE and OE are high, the data bus enable and rsp_valid are low, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this cycle when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address: row in 18:9, column in 8:0 |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 16 | Read data |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Data driven to the device |
| dram_dq_oe_o | output | 1 | Data bus drive enable |
| dram_dq_i | input | 16 | Data returned by the device |

## Verification
The forced close of an open row (idle expiry or the RAS-low ceiling) and the arrival of a new same-row request can land in the same cycle. The bench provokes this by sweeping the gap between requests across IDLE_MAX and by streaming same-row reads long enough to hit the RAS-low ceiling. It judges the outcome with a behavioural DRAM whose read data is only valid once the access latencies are met, a data scoreboard, a count of RAS falls and a measured bound on every RAS-low period.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // RAS high, precharged
    ST_ROW,    // row on pins, RAS still high
    ST_RCD,    // RAS low, row held
    ST_COL,    // column on pins, WE set for writes
    ST_CAS,    // CAS low
    ST_CP,     // CAS high after pulse
    ST_OPEN,   // row open, waiting
    ST_CLOSE,  // waiting out minimum RAS low
    ST_PRE     // precharge
  } fpm_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_age_cnt.sv
module fpm_age_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fpm_addr_map.sv
module fpm_addr_map #(
  parameter int ROW_W = 10,
  parameter int COL_W = 9,
  parameter int PIN_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   sel_row_i,
  output logic                   hit_o,
  output logic [PIN_W-1:0]       pin_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (cap_i) begin
      row_q <= addr_i[ROW_W+COL_W-1:COL_W];
      col_q <= addr_i[COL_W-1:0];
    end
  end

  // incoming row against the latched (open) row
  assign hit_o = (addr_i[ROW_W+COL_W-1:COL_W] == row_q);
  assign pin_o = sel_row_i ? PIN_W'(row_q) : PIN_W'(col_q);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int T_CP     = 2,
  parameter int T_RCD    = 2,
  parameter int CAS_CYC  = 3,
  parameter int IDLE_MAX = 16,
  parameter int RAS_LIM  = 50,
  parameter int AGE_W    = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  input  logic hit_i,
  output logic req_ready_o,
  output logic cap_o,
  output logic sel_row_o,
  output logic rd_cap_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);
  localparam int MAXD = max_u(max_u(T_RCD, CAS_CYC), max_u(T_CP, T_RP));
  localparam int TW   = (MAXD < 2) ? 1 : $clog2(MAXD);

  fpm_state_e state_q, state_d;
  logic       wr_q, wr_d, pend_q, pend_d;
  logic       tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic [AGE_W-1:0] ras_age, idle_age;
  logic       force_close, accept, idle_clr;

  fpm_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  fpm_age_cnt #(.W(AGE_W)) u_ras_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ras_no), .cnt_o(ras_age)
  );

  fpm_age_cnt #(.W(AGE_W)) u_idle_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(idle_clr), .cnt_o(idle_age)
  );

  assign force_close = (idle_age >= AGE_W'(IDLE_MAX - 1)) ||
                       (ras_age  >= AGE_W'(RAS_LIM));
  assign req_ready_o = (state_q == ST_IDLE) ||
                       ((state_q == ST_OPEN) && !force_close);
  assign accept      = req_valid_i && req_ready_o;
  assign idle_clr    = (state_q != ST_OPEN) || accept;

  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    pend_d   = pend_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_o    = 1'b0;
    rd_cap_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        cap_o   = 1'b1;
        wr_d    = req_we_i;
        state_d = ST_ROW;
      end
      ST_ROW: begin
        pend_d   = 1'b0;
        state_d  = ST_RCD;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RCD - 1);
      end
      ST_RCD: if (tmr_zero) state_d = ST_COL;
      ST_COL: begin
        state_d  = ST_CAS;
        tmr_load = 1'b1;
        tmr_val  = TW'(CAS_CYC - 1);
      end
      ST_CAS: if (tmr_zero) begin
        state_d  = ST_CP;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_CP - 1);
        rd_cap_o = !wr_q;
      end
      ST_CP: if (tmr_zero) state_d = ST_OPEN;
      ST_OPEN: begin
        if (force_close) state_d = ST_CLOSE;
        else if (req_valid_i) begin
          cap_o = 1'b1;
          wr_d  = req_we_i;
          if (hit_i) state_d = ST_COL;
          else begin
            state_d = ST_CLOSE;
            pend_d  = 1'b1;
          end
        end
      end
      ST_CLOSE: if (ras_age >= AGE_W'(T_RAS - 1)) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RP - 1);
      end
      ST_PRE: if (tmr_zero) state_d = pend_q ? ST_ROW : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      pend_q  <= pend_d;
    end
  end

  // pin decode from the state register
  assign ras_no    = (state_q == ST_IDLE) || (state_q == ST_ROW) || (state_q == ST_PRE);
  assign cas_no    = (state_q != ST_CAS);
  assign we_no     = !(wr_q && ((state_q == ST_COL) || (state_q == ST_CAS)));
  assign oe_no     = !(!wr_q && (state_q == ST_CAS));
  assign dq_oe_o   = wr_q && ((state_q == ST_COL) || (state_q == ST_CAS) || (state_q == ST_CP));
  assign sel_row_o = (state_q == ST_IDLE) || (state_q == ST_ROW) ||
                     (state_q == ST_RCD)  || (state_q == ST_PRE);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int COL_W    = 9,
  parameter int DATA_W   = 16,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int T_CP     = 2,
  parameter int T_RCD    = 2,
  parameter int T_CAC    = 2,
  parameter int T_CAA    = 4,
  parameter int IDLE_MAX = 16,
  parameter int RAS_MAX  = 64,
  localparam int ADDR_W  = ROW_W + COL_W,
  localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [PIN_W-1:0]  dram_addr_o,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  // CAS low long enough for both CAS access and column access (column leads CAS by one cycle)
  localparam int CAS_CYC = max_u(T_CAC, (T_CAA > 1) ? T_CAA - 1 : 1);
  localparam int ACC_CYC = 1 + CAS_CYC + T_CP;
  localparam int RAS_LIM = RAS_MAX - ACC_CYC - 3;
  localparam int AGE_W   = $clog2(max_u(IDLE_MAX, RAS_MAX) + 2);

  logic cap, sel_row, hit, rd_cap;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic rsp_valid_q;

  fpm_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .addr_i   (req_addr_i),
    .sel_row_i(sel_row),
    .hit_o    (hit),
    .pin_o    (dram_addr_o)
  );

  fpm_seq #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD),
    .CAS_CYC(CAS_CYC), .IDLE_MAX(IDLE_MAX), .RAS_LIM(RAS_LIM), .AGE_W(AGE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .hit_i      (hit),
    .req_ready_o(req_ready_o),
    .cap_o      (cap),
    .sel_row_o  (sel_row),
    .rd_cap_o   (rd_cap),
    .ras_no     (dram_ras_no),
    .cas_no     (dram_cas_no),
    .we_no      (dram_we_no),
    .oe_no      (dram_oe_no),
    .dq_oe_o    (dram_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      if (cap && req_we_i) wdata_q <= req_wdata_i;
      if (rd_cap)          rdata_q <= dram_dq_i;
      rsp_valid_q <= rd_cap;
    end
  end

  assign dram_dq_o   = wdata_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_valid_o = rsp_valid_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RAS   = 6,
  parameter int T_RP    = 4,
  parameter int T_CP    = 2,
  parameter int RAS_MAX = 64,
  parameter int PIN_W   = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             dram_ras_no,
  input logic             dram_cas_no,
  input logic             dram_we_no,
  input logic             dram_oe_no,
  input logic [PIN_W-1:0] dram_addr_o,
  input logic             dram_dq_oe_o
);
  logic [15:0] lo_cnt, hi_cnt, chi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= 16'(T_RP);
      chi_cnt <= 16'(T_CP);
    end else begin
      lo_cnt  <= dram_ras_no  ? '0 : ((lo_cnt  != '1) ? lo_cnt  + 1'b1 : lo_cnt);
      hi_cnt  <= !dram_ras_no ? '0 : ((hi_cnt  != '1) ? hi_cnt  + 1'b1 : hi_cnt);
      chi_cnt <= !dram_cas_no ? '0 : ((chi_cnt != '1) ? chi_cnt + 1'b1 : chi_cnt);
    end
  end

  p_row_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> $stable(dram_addr_o));
  p_ras_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no) |-> lo_cnt >= 16'(T_RAS));
  p_precharge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> hi_cnt >= 16'(T_RP));
  p_cas_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> chi_cnt >= 16'(T_CP));
  p_cas_in_ras_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  p_read_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> (dram_we_no && !dram_dq_oe_o && !dram_cas_no));
  p_early_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_we_no) |-> $past(!dram_we_no));
  p_write_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> (dram_oe_no && dram_dq_oe_o));
  p_dq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dram_cas_no) && $past(!dram_we_no)) |-> dram_dq_oe_o);
  p_ras_ceiling_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_ras_no |-> lo_cnt < 16'(RAS_MAX));
  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no || $rose(dram_ras_no)) |-> !req_ready_o);
  p_rsp_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .RAS_MAX(RAS_MAX), .PIN_W(PIN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .dram_ras_no (dram_ras_no),
  .dram_cas_no (dram_cas_no),
  .dram_we_no  (dram_we_no),
  .dram_oe_no  (dram_oe_no),
  .dram_addr_o (dram_addr_o),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int T_RAS = 6, T_RP = 4, T_CP = 2, T_CAC = 2, T_CAA = 4;
  localparam int IDLE_MAX = 16, RAS_MAX = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] dq_i = 16'hBAD0;
  logic        ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [15:0] rsp_rdata, dq_o;
  logic [9:0]  addr_p;

  fpm_dram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_addr_o(addr_p), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int checks = 0, fails = 0;
  bit run = 1'b0, done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_pat(logic [18:0] a);
    return 16'(a * 19'd40503) ^ {a[18:13], a[9:0]};
  endfunction

  // behavioural device and reference
  logic [15:0] dev_mem [int unsigned];
  logic [15:0] ref_mem [int unsigned];
  logic [15:0] rd_q[$];
  logic [18:0] srv_q[$];

  function automatic logic [15:0] dev_rd(logic [18:0] a);
    return dev_mem.exists(a) ? dev_mem[a] : init_pat(a);
  endfunction
  function automatic logic [15:0] ref_rd(logic [18:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : init_pat(a);
  endfunction

  logic       pr_ras = 1'b1, pr_cas = 1'b1, pr_we = 1'b1;
  logic [9:0] pr_addr = '0;
  logic [9:0] row_l = '0;
  logic [8:0] col_l = '0;
  int lo = 0, hi = 100, chi = 100, clo = 0, cage = 0, max_lo = 0, falls = 0;

  always @(negedge clk) if (run) begin
    if (!ras_n) begin
      if (pr_ras) begin
        falls++; row_l = addr_p; lo = 1;
        chk(hi >= T_RP, "R3 precharge", hi, T_RP);
      end else lo++;
    end else begin
      if (!pr_ras) begin
        chk(lo >= T_RAS, "R2 ras low", lo, T_RAS);
        chk(lo <= RAS_MAX, "R10 ras ceiling", lo, RAS_MAX);
        if (lo > max_lo) max_lo = lo;
        hi = 1;
      end else hi++;
    end
    cage = (addr_p == pr_addr) ? cage + 1 : 1;
    if (!cas_n) begin
      if (pr_cas) begin
        clo = 1;
        col_l = addr_p[8:0];
        chk(!ras_n, "R4 cas inside ras", ras_n, 0);
        chk(chi >= T_CP, "R3 cas high", chi, T_CP);
        if (srv_q.size() == 0) chk(0, "R1 unexpected access", {row_l, col_l}, 0);
        else begin
          logic [18:0] ea;
          ea = srv_q.pop_front();
          chk({row_l, col_l} == ea, "R1 row/col split", {row_l, col_l}, ea);
        end
        if (!we_n) begin
          chk(!pr_we, "R5 early write", pr_we, 0);
          chk(dq_oe && oe_n, "R5 write bus", {dq_oe, oe_n}, 3);
          dev_mem[{row_l, col_l}] = dq_o;
        end
      end else clo++;
      chk(!ready, "R11 busy in cas", ready, 0);
    end else begin
      chi = pr_cas ? chi + 1 : 1;
    end
    if (!ras_n && !cas_n && we_n && !oe_n && clo >= T_CAC && cage >= T_CAA)
      dq_i = dev_rd({row_l, col_l});
    else
      dq_i = 16'hBAD0;
    if (rsp_valid) begin
      if (rd_q.size() == 0) chk(0, "R11 spurious response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = rd_q.pop_front();
        chk(rsp_rdata == e, "R4 R8 read data", rsp_rdata, e);
      end
    end
    pr_ras = ras_n; pr_cas = cas_n; pr_we = we_n; pr_addr = addr_p;
  end

  task automatic send(bit we, logic [18:0] a, logic [15:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!ready) @(negedge clk);
    srv_q.push_back(a);
    if (we) ref_mem[a] = d;
    else    rd_q.push_back(ref_rd(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (rd_q.size() != 0 || srv_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_closed(string tag);
    repeat (IDLE_MAX + T_RAS + T_CP + 4) @(negedge clk);
    chk(ras_n == 1'b1, tag, ras_n, 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R12 strobes high", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !rsp_valid, "R12 bus and rsp idle", {dq_oe, rsp_valid}, 0);
    chk(ready, "R12 ready", ready, 1);

    // write then read one word
    send(1'b1, {10'd5, 9'd3}, 16'hA5C3);
    send(1'b0, {10'd5, 9'd3}, 16'h0);
    drain();
    wait_closed("R9 idle close");

    // R6 page hits: one activation for a same-row burst, columns at both ends
    f0 = falls;
    send(1'b1, {10'd7, 9'd0},   16'h1111);
    send(1'b1, {10'd7, 9'd511}, 16'h2222);
    send(1'b1, {10'd7, 9'd100}, 16'h3333);
    send(1'b0, {10'd7, 9'd511}, 16'h0);
    send(1'b0, {10'd7, 9'd0},   16'h0);
    send(1'b0, {10'd7, 9'd100}, 16'h0);
    send(1'b0, {10'd7, 9'd200}, 16'h0);
    drain();
    chk(falls - f0 == 1, "R6 single activation", falls - f0, 1);

    // R7 row miss while open
    send(1'b0, {10'd8, 9'd100}, 16'h0);
    drain();
    chk(falls - f0 == 2, "R7 reopen on miss", falls - f0, 2);
    wait_closed("R9 idle close after miss");

    // gap sweep across the idle expiry
    for (int g = IDLE_MAX - 4; g <= IDLE_MAX + 4; g++) begin
      send(1'b0, {10'd9, 9'(g)}, 16'h0);
      drain();
      repeat (g) @(negedge clk);
      send(g[0], {10'd9, 9'(g + 1)}, 16'(g * 77));
    end
    drain();

    // R10 continuous same-row stream past the ceiling
    wait_closed("R9 idle close before stream");
    f0 = falls;
    for (int i = 0; i < 40; i++) send(1'b0, {10'd10, 9'(i * 13)}, 16'h0);
    drain();
    chk(falls - f0 >= 2, "R10 forced reopen", falls - f0, 2);
    chk(max_lo <= RAS_MAX, "R10 longest ras low", max_lo, RAS_MAX);

    // address extremes
    send(1'b1, {10'd1023, 9'd511}, 16'hFEED);
    send(1'b1, {10'd0, 9'd0}, 16'hBEEF);
    send(1'b0, {10'd1023, 9'd511}, 16'h0);
    send(1'b0, {10'd0, 9'd0}, 16'h0);
    drain();

    // random mix over a few rows
    for (int i = 0; i < 400; i++) begin
      logic [9:0] r;
      int gap;
      case ($urandom % 4)
        0: r = 10'd0;
        1: r = 10'd1023;
        default: r = 10'($urandom % 3 + 20);
      endcase
      send(1'($urandom % 2), {r, 9'($urandom)}, 16'($urandom));
      gap = ($urandom % 8 == 0) ? IDLE_MAX + int'($urandom % 6) - 3 : int'($urandom % 3);
      repeat (gap) @(negedge clk);
    end
    drain();
    wait_closed("R9 idle close at end");
    chk(rd_q.size() == 0, "R11 all reads answered", rd_q.size(), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule